// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a short global record of the most recent resolved branch outcomes. It also keeps a table of rows, and the low bits of the branch address select one row. Each row holds one small counter for every possible value of the global record. The current record value picks which counter in the row gives the prediction. When a branch resolves, only the counter that was used for it is trained. A table with a record width of zero would behave as a plain per-address counter table; this implementation needs a record of at least one bit.

A fetch stage presents a lookup address and receives the prediction together with the record value used to make it. The caller carries that record value along with the branch. When the branch resolves, the caller returns the address, the carried record value and the real outcome. The resolved outcome is always shifted into the global record, whichever row the branch used. The table has a combinational read and a single write port. A lookup in the same cycle as an update therefore sees the state from before that update.

Top module: `corr_predictor`

## Requirements
- R1: After reset the global record is 0 and every counter is 00, so every lookup predicts not taken.
- R2: The row is chosen by lookup address bits [11:2] (default 1024 rows, 4-byte aligned). Address bits 1:0 and bits above 11 have no effect, so addresses that differ only in those bits share a row.
- R3: The prediction is the most significant bit of the counter in the selected row at the position equal to the live global record (record 01 reads counter 1, record 11 reads counter 3).
- R4: On each update the record shifts left by one. The resolved outcome (1 = taken) enters bit 0 and the oldest bit is dropped, whichever address was updated: 01 followed by taken gives 11, and 11 followed by not taken gives 10.
- R5: While update valid is low, neither the record nor any counter changes, whatever the other update inputs carry.
- R6: An update changes only one counter: the one in the row of the update address at the position given by the update record. The other counters of that row and all other rows keep their values.
- R7: Each 2-bit counter moves as follows. Taken: 00→01, 01→11, 10→11, 11→11. Not taken: 00→00, 01→00, 10→00, 11→10.
- R8: The record output always shows the live global record, which is the value that selects the counter for the prediction.
- R9: An update trains the counter chosen by the record value supplied with the update, not the live record.
- R10: A lookup in the same cycle as an update of the same counter returns the prediction from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lookup_pc | input | 32 | Address of the branch being predicted |
| pred_taken | output | 1 | Prediction, 1 = taken |
| pred_hist | output | 2 | Live global record, to be carried with the branch |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | 32 | Address of the resolved branch |
| upd_hist | input | 2 | Record value carried from the branch's lookup |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench walks every counter position of one row through a long taken/not-taken pattern. This visits all eight counter transitions. A counter that saturated the wrong way, or that skipped the weak-taken state, would break the prediction sequence. After each training step it reads the neighbouring position and the neighbouring row. A write that reached the wrong position or spilled over into other counters would show up there. It sets the global record to any value by training a separate scratch row. Using this, it checks that a supplied record value other than the live one selects the trained counter. It also checks that aliased addresses share a row, that a same-cycle lookup returns the old prediction, and that an update with valid low changes nothing.

// File: rtl/corr_pred_pkg.sv
package corr_pred_pkg;

  // Next counter state. Width 2 uses the hysteresis scheme, other widths saturate.
  function automatic logic [7:0] ctr_next(input logic [7:0] cur, input logic taken,
                                          input int unsigned w);
    logic [8:0] span;
    logic [7:0] top;
    span = (9'd1 << w) - 9'd1;
    top  = span[7:0];
    if (w == 2) begin
      if (taken) return (cur == 8'd0) ? 8'd1 : 8'd3;
      else       return (cur == 8'd3) ? 8'd2 : 8'd0;
    end
    if (taken) return (cur == top) ? cur : cur + 8'd1;
    return (cur == 8'd0) ? cur : cur - 8'd1;
  endfunction

  function automatic logic msb_of(input logic [7:0] c, input int unsigned w);
    return c[w-1];
  endfunction

endpackage

// File: rtl/corr_hist_reg.sv
module corr_hist_reg #(
  parameter int HIST_BITS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 shift_en,
  input  logic                 outcome,
  output logic [HIST_BITS-1:0] hist_q
);

  logic [HIST_BITS-1:0] hist_d;

  generate
    if (HIST_BITS > 1) begin : g_wide
      assign hist_d = {hist_q[HIST_BITS-2:0], outcome};
    end else begin : g_single
      assign hist_d = outcome;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        hist_q <= '0;
    else if (shift_en) hist_q <= hist_d;
  end

  assert_newest_at_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(outcome));

  generate
    if (HIST_BITS > 1) begin : g_chk
      assert_older_shift_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_q[HIST_BITS-1:1] == $past(hist_q[HIST_BITS-2:0]));
    end
  endgenerate

  assert_hist_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && $past(rst_n)) |=> $stable(hist_q));

endmodule

// File: rtl/corr_pred_table.sv
module corr_pred_table
  import corr_pred_pkg::*;
#(
  parameter int ENTRIES   = 1024,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  localparam int IDX_BITS = $clog2(ENTRIES),
  localparam int SLOTS    = 1 << HIST_BITS,
  localparam int ROW_W    = SLOTS * CTR_BITS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [IDX_BITS-1:0]  rd_idx,
  input  logic [HIST_BITS-1:0] rd_sel,
  output logic                 rd_taken,
  input  logic                 wr_en,
  input  logic [IDX_BITS-1:0]  wr_idx,
  input  logic [HIST_BITS-1:0] wr_sel,
  input  logic                 wr_taken
);

  logic [ROW_W-1:0] rows_q [ENTRIES];

  logic [ROW_W-1:0]    rd_row;
  logic [CTR_BITS-1:0] rd_ctr;
  logic [ROW_W-1:0]    wr_row_old;
  logic [ROW_W-1:0]    wr_mask;
  logic [CTR_BITS-1:0] wr_ctr_old;
  logic [CTR_BITS-1:0] wr_ctr_new;
  logic [7:0]          wr_ctr_calc;

  assign rd_row   = rows_q[rd_idx];
  assign rd_ctr   = rd_row[int'(rd_sel)*CTR_BITS +: CTR_BITS];
  assign rd_taken = msb_of(8'(rd_ctr), CTR_BITS);

  assign wr_row_old  = rows_q[wr_idx];
  assign wr_ctr_old  = wr_row_old[int'(wr_sel)*CTR_BITS +: CTR_BITS];
  assign wr_ctr_calc = ctr_next(8'(wr_ctr_old), wr_taken, CTR_BITS);
  assign wr_ctr_new  = wr_ctr_calc[CTR_BITS-1:0];
  assign wr_mask     = ROW_W'({CTR_BITS{1'b1}}) << (int'(wr_sel)*CTR_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) rows_q[i] <= '0;
    end else if (wr_en) begin
      rows_q[wr_idx][int'(wr_sel)*CTR_BITS +: CTR_BITS] <= wr_ctr_new;
    end
  end

  assert_others_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((rows_q[$past(wr_idx)] ^ $past(wr_row_old)) & ~$past(wr_mask)) == '0);

  assert_taken_keeps_taken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_ctr_old[CTR_BITS-1]) |-> wr_ctr_new[CTR_BITS-1]);

  assert_nottaken_keeps_nottaken_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && !wr_ctr_old[CTR_BITS-1]) |-> !wr_ctr_new[CTR_BITS-1]);

  assert_write_moves_ctr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_ctr_old != {CTR_BITS{1'b1}}) |-> wr_ctr_new != wr_ctr_old);

endmodule

// File: rtl/corr_predictor.sv
module corr_predictor #(
  parameter int PC_W      = 32,
  parameter int IDX_LSB   = 2,
  parameter int ENTRIES   = 1024,
  parameter int HIST_BITS = 2,
  parameter int CTR_BITS  = 2,
  localparam int IDX_BITS = $clog2(ENTRIES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PC_W-1:0]      lookup_pc,
  output logic                 pred_taken,
  output logic [HIST_BITS-1:0] pred_hist,
  input  logic                 upd_valid,
  input  logic [PC_W-1:0]      upd_pc,
  input  logic [HIST_BITS-1:0] upd_hist,
  input  logic                 upd_taken
);

  function automatic logic [IDX_BITS-1:0] pc_to_row(input logic [PC_W-1:0] pc);
    return pc[IDX_LSB +: IDX_BITS];
  endfunction

  logic [IDX_BITS-1:0] look_row;
  logic [IDX_BITS-1:0] upd_row;
  logic [HIST_BITS-1:0] live_hist;

  assign look_row  = pc_to_row(lookup_pc);
  assign upd_row   = pc_to_row(upd_pc);
  assign pred_hist = live_hist;

  corr_hist_reg #(.HIST_BITS(HIST_BITS)) hist_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .outcome  (upd_taken),
    .hist_q   (live_hist)
  );

  corr_pred_table #(
    .ENTRIES   (ENTRIES),
    .HIST_BITS (HIST_BITS),
    .CTR_BITS  (CTR_BITS)
  ) table_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (look_row),
    .rd_sel   (live_hist),
    .rd_taken (pred_taken),
    .wr_en    (upd_valid),
    .wr_idx   (upd_row),
    .wr_sel   (upd_hist),
    .wr_taken (upd_taken)
  );

  initial begin
    assert_params_R3: assert (HIST_BITS >= 1 && CTR_BITS >= 1 && CTR_BITS <= 8
                              && IDX_LSB + IDX_BITS <= PC_W);
  end

endmodule

// File: tb/corr_predictor_tb_top.sv
module corr_predictor_tb_top;

  localparam logic [31:0] ROW_E  = 32'h0000_0040;
  localparam logic [31:0] ROW_E2 = 32'h0000_0100;
  localparam logic [31:0] ROW_E3 = 32'h0000_0204;
  localparam logic [31:0] SCR    = 32'h0000_0800;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [31:0] lookup_pc;
  logic        pred_taken;
  logic [1:0]  pred_hist;
  logic        upd_valid;
  logic [31:0] upd_pc;
  logic [1:0]  upd_hist;
  logic        upd_taken;

  corr_predictor dut_i (
    .clk(clk), .rst_n(rst_n), .lookup_pc(lookup_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_hist(upd_hist), .upd_taken(upd_taken)
  );

  logic [1:0] mdl [1024][4];
  logic [1:0] mhist;
  int errs = 0;
  int checks = 0;

  function automatic logic [1:0] step(input logic [1:0] s, input logic t);
    case ({s, t})
      3'b00_1: return 2'b01;
      3'b01_1: return 2'b11;
      3'b10_1: return 2'b11;
      3'b11_1: return 2'b11;
      3'b11_0: return 2'b10;
      default: return 2'b00;
    endcase
  endfunction

  function automatic int row_of(input logic [31:0] pc);
    return int'(pc[11:2]);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic upd(input logic [31:0] pc, input logic [1:0] h, input logic t);
    @(negedge clk);
    upd_pc = pc; upd_hist = h; upd_taken = t; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    mdl[row_of(pc)][h] = step(mdl[row_of(pc)][h], t);
    mhist = {mhist[0], t};
  endtask

  task automatic steer(input logic [1:0] k);
    upd(SCR, mhist, k[1]);
    upd(SCR, mhist, k[0]);
  endtask

  task automatic peek(input logic [31:0] pc, input logic [1:0] k, input string req);
    steer(k);
    lookup_pc = pc;
    #1;
    chk("R8 record", 8'(pred_hist), 8'(k));
    chk(req, 8'(pred_taken), 8'(mdl[row_of(pc)][k][1]));
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    for (int r = 0; r < 1024; r++)
      for (int s = 0; s < 4; s++) mdl[r][s] = 2'b00;
    mhist = 2'b00;
    rst_n = 1'b0; upd_valid = 1'b0; upd_pc = '0; upd_hist = '0; upd_taken = 1'b0;
    lookup_pc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1: reset state
    chk("R1 record", 8'(pred_hist), 8'd0);
    for (int p = 0; p < 6; p++) begin
      lookup_pc = 32'(p) * 32'h0000_0124;
      #1;
      chk("R1 predict", 8'(pred_taken), 8'd0);
    end

    // R7, R6, R3: every slot of one row through a full transition pattern
    for (int k = 0; k < 4; k++) begin
      logic [13:0] pat;
      pat = 14'b11010011100110 ^ 14'(k * 5);
      for (int i = 0; i < 14; i++) begin
        upd(ROW_E, 2'(k), pat[i]);
        peek(ROW_E, 2'(k), "R7 transition");
        peek(ROW_E, 2'(k + 1), "R6 other slot");
        peek(ROW_E + 32'h4, 2'(k), "R6 other row");
      end
      peek(ROW_E | 32'h3, 2'(k), "R2 low bits");
      peek(ROW_E + 32'h0001_0000, 2'(k), "R2 high alias");
      peek(ROW_E, 2'(k), "R3 selected slot");
    end

    // R4: history shift regardless of address
    upd(ROW_E2, 2'b00, 1'b0);
    upd(ROW_E2, 2'b00, 1'b1);
    #1 chk("R4 shift 01", 8'(pred_hist), 8'h1);
    upd(ROW_E3, 2'b11, 1'b1);
    #1 chk("R4 shift 11", 8'(pred_hist), 8'h3);
    upd(ROW_E2, 2'b10, 1'b0);
    #1 chk("R4 shift 10", 8'(pred_hist), 8'h2);

    // R9: supplied record differs from the live one
    for (int j = 0; j < 4; j++) begin
      logic [1:0] hs;
      hs = ~mhist;
      upd(ROW_E2, hs, 1'b1);
      upd(ROW_E2, hs, 1'b1);
      peek(ROW_E2, hs, "R9 supplied record");
      peek(ROW_E2, ~hs, "R9 live record slot");
    end

    // R5: update inputs toggle with valid low
    begin
      logic [1:0] held;
      held = mhist;
      for (int j = 0; j < 6; j++) begin
        @(negedge clk);
        upd_pc = ROW_E2; upd_hist = 2'(j); upd_taken = j[0];
        lookup_pc = ROW_E2;
        #1 chk("R5 record held", 8'(pred_hist), 8'(held));
      end
      for (int k = 0; k < 4; k++) peek(ROW_E2, 2'(k), "R5 counters held");
    end

    // R10: same-cycle lookup sees old state
    begin
      logic [1:0] h;
      h = {mhist[0], 1'b1};
      upd(ROW_E3 + 32'h40, h, 1'b1);
      @(negedge clk);
      lookup_pc = ROW_E3 + 32'h40;
      upd_pc = ROW_E3 + 32'h40; upd_hist = h; upd_taken = 1'b1; upd_valid = 1'b1;
      #1;
      chk("R10 old value", 8'(pred_taken), 8'd0);
      @(negedge clk);
      upd_valid = 1'b0;
      mdl[row_of(ROW_E3 + 32'h40)][h] = step(mdl[row_of(ROW_E3 + 32'h40)][h], 1'b1);
      mhist = {mhist[0], 1'b1};
      peek(ROW_E3 + 32'h40, h, "R10 new value");
    end

    summary();
  end

endmodule